// File: doc/BRIEF.md
# Multi-Channel Ramp-Crossing Timer

This block is the digital timing half of a ramp-compare analog-to-digital converter that digitises four inputs at once. A start pulse, normally the PWM period synchronisation strobe, begins a conversion. The block first holds the ramp capacitor discharged for a programmable number of clocks. It then releases the discharge output so an external constant-current ramp can rise, and it runs a 12-bit elapsed-time counter. Each channel has its own comparator. The counter value at the first rising edge of that comparator becomes the channel's result, so the stored code grows with input voltage.

The fourth channel reaches its comparator through an external 4-to-1 multiplexer. The block drives the 2-bit select for it and holds the select steady for the whole conversion. The highest code routes the internal reference so software can calibrate. Results, per-channel overrange flags and a completion flag are read through a small combinational read port.

Top module: `ss_adc_timer`

## Requirements
- R1: After reset, cap_rst_o is 1, aux_mux_o is 0, every result reads 0 and the status word reads 0.
- R2: A start pulse sampled at a clock edge holds cap_rst_o at 1 for max(H,1) clocks, where H is rst_hold_i sampled with that pulse. It then drives cap_rst_o to 0 for the whole ramp and returns it to 1 once the conversion completes.
- R3: The ramp counter starts at 0 in the first ramp cycle and increments once per clock. Comparators pass through two synchroniser flops and an edge detector. If a comparator goes high in ramp cycle j, that channel stores j+2. The offset is the same on all four channels, and all four are captured independently in one conversion.
- R4: Across channels and conversions, a later comparator crossing never stores a smaller result.
- R5: Only the first rising comparator edge after the start is captured. Later toggles in the same conversion leave the result unchanged.
- R6: A channel with no capture when the counter is at 4095 stores 4095, and its overrange flag (status bit equal to the channel index) is set. A capture in the 4095 cycle itself stores 4095 without the flag.
- R7: Status bit 8 (done) sets once all four channels have captured or the counter has saturated. It clears in the cycle after the next start pulse.
- R8: aux_mux_o takes aux_sel_i at each start pulse: 00, 01 and 10 pick auxiliary inputs 0 to 2, and 11 picks the calibration reference. Changes to aux_sel_i between start pulses do not affect aux_mux_o.
- R9: Read addresses 0 to 3 return the result of that channel, zero-extended to 16 bits. Address 4 returns status. Every other address returns 0.
- R10: A start pulse during a conversion abandons it. It clears the results, flags and done, and begins a new discharge phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_i | input | 1 | Conversion start pulse |
| rst_hold_i | input | 8 | Discharge hold length in clocks, sampled at start |
| aux_sel_i | input | 2 | Auxiliary multiplexer select, sampled at start |
| cmp_i | input | 4 | Asynchronous comparator outputs, one per channel |
| cap_rst_o | output | 1 | Ramp capacitor discharge control, active high |
| aux_mux_o | output | 2 | Select driven to the external multiplexer |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 16 | Read data |

## Verification
The bench models the ramp as a cycle index that restarts whenever the discharge output is high, and trips each comparator at a threshold chosen per channel. The threshold sets are ascending, descending, all-zero, adjacent and widely spread. These separate a per-channel capture from a shared one and expose any latency that differs between channels. Thresholds at 4093, 4094 and beyond separate a normal capture at the last count from a saturated one. A glitch pattern that re-crosses after the first edge shows whether later edges can overwrite a result. Restarts in the middle of a ramp and select changes in the middle of a conversion show whether a new start pulse and the select input act only at the intended moments.

// File: rtl/ssadc_pkg.sv
// Package: shared types for the ramp-crossing timer.
package ssadc_pkg;
    // Conversion sequencer phases.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DISCH = 2'd1,
        ST_RAMP  = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/ssadc_sync.sv
// Module: ssadc_sync
// Brings NUM_CH asynchronous comparator lines into the clock domain through
// two flops each, then flags a rising edge with one more history flop.
// Assumes the comparator lines are level signals that are slow relative to clk.
module ssadc_sync #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] cmp_i,
    output logic [NUM_CH-1:0] rise_o
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic s1, s2, s3;

        // Two-stage synchroniser followed by a history flop.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
                s3 <= 1'b0;
            end else begin
                s1 <= cmp_i[c];
                s2 <= s1;
                s3 <= s2;
            end
        end

        assign rise_o[c] = s2 & ~s3;
    end
endmodule

// File: rtl/ssadc_seq.sv
// Module: ssadc_seq
// Runs a conversion: discharge hold, then a ramp with an elapsed-time counter,
// then done. A start pulse in any phase restarts from discharge.
// Assumes hold_i is sampled only together with start_i.
module ssadc_seq
    import ssadc_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [HOLD_W-1:0] hold_i,
    input  logic              all_capt_i,
    output seq_state_e        state_o,
    output logic [CNT_W-1:0]  count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [HOLD_W-1:0] hold_left;

    // Phase transitions, hold countdown and ramp counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o   <= ST_IDLE;
            count_o   <= '0;
            hold_left <= '0;
        end else if (start_i) begin
            state_o   <= ST_DISCH;
            count_o   <= '0;
            hold_left <= hold_i;
        end else begin
            case (state_o)
                ST_DISCH: begin
                    if (hold_left <= HOLD_W'(1)) state_o <= ST_RAMP;
                    else                         hold_left <= hold_left - 1'b1;
                    count_o <= '0;
                end
                ST_RAMP: begin
                    if (all_capt_i || count_o == CNT_MAX) state_o <= ST_DONE;
                    else                                  count_o <= count_o + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R3: the counter steps by exactly one inside a running ramp
    a_r3_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_RAMP && $past(state_o) == ST_RAMP && !$past(start_i))
        |-> count_o == CNT_W'($past(count_o) + 1'b1));

    // R2: every ramp begins from a zero count
    a_r2_ramp_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_o == ST_RAMP) |-> count_o == '0);
endmodule

// File: rtl/ssadc_chan.sv
// Module: ssadc_chan
// One result slot: latches the count on the first comparator edge of a ramp,
// or the saturated count with an overrange flag if none arrives.
// Assumes clear_i is the start pulse and arm_i is high only during the ramp.
module ssadc_chan #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             arm_i,
    input  logic             rise_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [CNT_W-1:0] result_o,
    output logic             captured_o,
    output logic             over_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Capture on the first edge; otherwise saturate at the last count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            result_o   <= '0;
            captured_o <= 1'b0;
            over_o     <= 1'b0;
        end else if (arm_i && !captured_o) begin
            if (rise_i) begin
                result_o   <= count_i;
                captured_o <= 1'b1;
            end else if (count_i == CNT_MAX) begin
                result_o   <= CNT_MAX;
                captured_o <= 1'b1;
                over_o     <= 1'b1;
            end
        end
    end

    // R5: once captured, the result holds until the next start
    a_r5_result_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(captured_o) && !$past(clear_i)) |-> $stable(result_o));

    // R6: an overrange flag always comes with the saturated code
    a_r6_over_is_max: assert property (@(posedge clk) disable iff (!rst_n)
        over_o |-> (result_o == CNT_MAX && captured_o));
endmodule

// File: rtl/ss_adc_timer.sv
// Module: ss_adc_timer
// Top of the ramp-crossing timer: synchronises comparators, sequences the
// discharge and ramp, captures each channel and serves a read port.
// Assumes DATA_W >= CNT_W, DATA_W > DONE_BIT and NUM_CH <= 8.
module ss_adc_timer
    import ssadc_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int NUM_CH = 4,
    parameter int HOLD_W = 8,
    parameter int SEL_W  = 2,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_i,
    input  logic [HOLD_W-1:0] rst_hold_i,
    input  logic [SEL_W-1:0]  aux_sel_i,
    input  logic [NUM_CH-1:0] cmp_i,
    output logic              cap_rst_o,
    output logic [SEL_W-1:0]  aux_mux_o,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int DONE_BIT = 8;
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_CH);

    seq_state_e        state;
    logic [CNT_W-1:0]  count;
    logic [NUM_CH-1:0] rise, captured, over;
    logic [CNT_W-1:0]  result [NUM_CH];
    logic              done;

    ssadc_sync #(.NUM_CH(NUM_CH)) sync_i0 (
        .clk(clk), .rst_n(rst_n), .cmp_i(cmp_i), .rise_o(rise)
    );

    ssadc_seq #(.CNT_W(CNT_W), .HOLD_W(HOLD_W)) seq_i0 (
        .clk(clk), .rst_n(rst_n), .start_i(sync_i), .hold_i(rst_hold_i),
        .all_capt_i(&captured), .state_o(state), .count_o(count)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        ssadc_chan #(.CNT_W(CNT_W)) chan_i (
            .clk(clk), .rst_n(rst_n), .clear_i(sync_i),
            .arm_i(state == ST_RAMP), .rise_i(rise[c]), .count_i(count),
            .result_o(result[c]), .captured_o(captured[c]), .over_o(over[c])
        );
    end

    // Multiplexer select is latched only at a start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)      aux_mux_o <= '0;
        else if (sync_i) aux_mux_o <= aux_sel_i;
    end

    assign cap_rst_o = (state != ST_RAMP);
    assign done      = (state == ST_DONE);

    // Read decode: results, then status, zero elsewhere.
    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i < STAT_ADDR) begin
            for (int c = 0; c < NUM_CH; c++)
                if (rd_addr_i == ADDR_W'(c)) rd_data_o = DATA_W'(result[c]);
        end else if (rd_addr_i == STAT_ADDR) begin
            rd_data_o[NUM_CH-1:0] = over;
            rd_data_o[DONE_BIT]   = done;
        end
    end

    // R7: done is gone one cycle after a start pulse
    a_r7_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> !done);

    // R8: the select moves only at a start pulse
    a_r8_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_i |=> $stable(aux_mux_o));

    // R2: the discharge output is low only while the ramp runs, never in done
    a_r2_release_only_ramp: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cap_rst_o);
endmodule

// File: tb/ss_adc_timer_tb_top.sv
module ss_adc_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_i = 1'b0;
    logic [7:0]  rst_hold_i = '0;
    logic [1:0]  aux_sel_i = '0;
    logic [3:0]  cmp_i;
    logic        cap_rst_o;
    logic [1:0]  aux_mux_o;
    logic [2:0]  rd_addr_i = '0;
    logic [15:0] rd_data_o;

    int tests = 0, fails = 0, cycles = 0;
    int thr [4] = '{5000, 5000, 5000, 5000};
    bit glitch_en = 1'b0;
    int j = 0;

    always #10 clk = ~clk;

    ss_adc_timer dut_i (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .rst_hold_i(rst_hold_i),
        .aux_sel_i(aux_sel_i), .cmp_i(cmp_i), .cap_rst_o(cap_rst_o),
        .aux_mux_o(aux_mux_o), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
    );

    // Ramp and comparator model: index restarts while the capacitor is discharged.
    initial cmp_i = '0;
    always @(negedge clk) begin
        if (cap_rst_o) begin
            j = 0;
            cmp_i = '0;
        end else begin
            for (int c = 0; c < 4; c++) begin
                cmp_i[c] = (j >= thr[c]);
                if (glitch_en && j >= thr[c] + 5 && j < thr[c] + 8) cmp_i[c] = 1'b0;
            end
            j++;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rd(input int addr, output int val);
        rd_addr_i = 3'(addr);
        #1;
        val = int'(rd_data_o);
    endtask

    task automatic start(input int h, input int sel, output int hold_seen);
        @(negedge clk);
        sync_i = 1'b1;
        rst_hold_i = 8'(h);
        aux_sel_i = 2'(sel);
        @(negedge clk);
        sync_i = 1'b0;
        hold_seen = 0;
        while (cap_rst_o && hold_seen < 300) begin
            hold_seen++;
            @(negedge clk);
        end
    endtask

    task automatic wait_done();
        int n = 0;
        int v;
        rd(4, v);
        while (v[8] == 0 && n < 6000) begin
            @(negedge clk);
            rd(4, v);
            n++;
        end
    endtask

    localparam int NV = 5;
    localparam int VT [NV][4] = '{'{10, 20, 30, 40}, '{40, 30, 20, 10},
                                  '{0, 0, 0, 0}, '{100, 101, 102, 103},
                                  '{7, 500, 7, 1000}};
    localparam int VH [NV] = '{3, 1, 0, 8, 2};
    localparam int VS [NV] = '{0, 1, 2, 3, 1};

    initial begin
        int v, hs, r [4];
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 cap_rst", int'(cap_rst_o), 1);
        check("R1 aux_mux", int'(aux_mux_o), 0);
        rd(0, v); check("R1 result0", v, 0);
        rd(4, v); check("R1 status", v, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 cap_rst after release", int'(cap_rst_o), 1);

        // Vector table walk: R2 R3 R4 R6 R7 R8
        for (int k = 0; k < NV; k++) begin
            for (int c = 0; c < 4; c++) thr[c] = VT[k][c];
            start(VH[k], VS[k], hs);
            check("R2 hold length", hs, (VH[k] < 1) ? 1 : VH[k]);
            check("R8 select code", int'(aux_mux_o), VS[k]);
            wait_done();
            rd(4, v);
            check("R7 done set", (v >> 8) & 1, 1);
            check("R6 no overrange", v & 15, 0);
            check("R2 discharge after done", int'(cap_rst_o), 1);
            for (int c = 0; c < 4; c++) begin
                rd(c, r[c]);
                check("R3 result", r[c], VT[k][c] + 2);
            end
            for (int a = 0; a < 4; a++)
                for (int b = 0; b < 4; b++)
                    if (VT[k][a] > VT[k][b])
                        check("R4 ordering", int'(r[a] >= r[b]), 1);
        end

        // R7: done clears after the next start
        @(negedge clk); sync_i = 1'b1; rst_hold_i = 8'd4;
        @(negedge clk); sync_i = 1'b0;
        rd(4, v); check("R7 done cleared", (v >> 8) & 1, 0);
        rd(0, v); check("R10 result cleared", v, 0);

        // R6: saturation and last-count capture
        thr = '{50, 5000, 4093, 4094};
        start(2, 0, hs);
        wait_done();
        rd(4, v); check("R6 overrange flags", v & 15, 4'b1010);
        rd(0, v); check("R6 normal channel", v, 52);
        rd(1, v); check("R6 saturated channel", v, 4095);
        rd(2, v); check("R6 capture at last count", v, 4095);
        rd(3, v); check("R6 one past last count", v, 4095);

        // R5: re-crossing comparator is ignored
        glitch_en = 1'b1;
        thr = '{10, 20, 30, 40};
        start(1, 2, hs);
        wait_done();
        for (int c = 0; c < 4; c++) begin
            rd(c, v); check("R5 first edge kept", v, thr[c] + 2);
        end
        glitch_en = 1'b0;

        // R8: select change mid-conversion has no effect; code 11 is calibration
        thr = '{200, 210, 220, 230};
        start(1, 3, hs);
        repeat (5) @(negedge clk);
        aux_sel_i = 2'b00;
        repeat (5) @(negedge clk);
        check("R8 select held mid-conversion", int'(aux_mux_o), 3);

        // R10: restart in the middle of a ramp
        thr = '{60, 70, 80, 90};
        rd(4, v); check("R10 not done before restart", (v >> 8) & 1, 0);
        start(3, 1, hs);
        check("R10 restart hold", hs, 3);
        check("R10 select reloaded", int'(aux_mux_o), 1);
        wait_done();
        for (int c = 0; c < 4; c++) begin
            rd(c, v); check("R10 fresh result", v, thr[c] + 2);
        end

        // R9: unused addresses read zero
        rd(5, v); check("R9 address 5", v, 0);
        rd(7, v); check("R9 address 7", v, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule